// File: doc/BRIEF.md
# Time-of-Day Clock with Roll-Over Interrupts

This block keeps the time of day in seconds, minutes and hours. It advances on a pulse input, `tick`, which arrives at a fixed rate of 2^DIV_LOG2 pulses per second; the default of 256 Hz would come from a divided 32 kHz crystal. An internal sub-second divider turns these pulses into four periodic events at 32, 8, 4 and 1 Hz. The 1 Hz event advances the seconds counter. Minute and hour carries ripple through in the same clock cycle.

Software controls the block through a small word-wide register port. A control word holds three bits: the run bit, a 12-hour/24-hour choice, and a choice of BCD or plain binary storage for seconds and minutes. One time word carries the whole time, so a single read returns a value that cannot be torn. The time word can be loaded only while the clock is stopped, and loading it restarts the sub-second divider. Nine event sources set sticky flags, which software clears by writing 1. A per-source enable mask selects which flags drive the single interrupt output.

Top module: `rtc_clock_top`

## Requirements
- R1: After reset, the control word (address 0) reads 0: the run bit (bit 0) is clear, hours use the 24-hour range (bit 1 = 0) and seconds/minutes use BCD (bit 2 = 0). The time word, the enable mask and the flags also read 0, and `irq` is low.
- R2: `tick` pulses are counted only while the run bit is 1. While stopped, ticks change neither the time nor any flag. While running, exactly 2^DIV_LOG2 ticks advance the seconds by one.
- R3: In BCD mode (control bit 2 = 0), seconds and minutes count 0x00..0x59 in packed BCD. Passing 0x59 wraps to 0x00 and advances the next counter on the same clock edge.
- R4: In binary mode (control bit 2 = 1), seconds and minutes count 0..59 as plain binary and wrap in the same way. Hours stay in BCD in both modes.
- R5: In 24-hour mode, the hour counts BCD 0x00..0x23 and wraps from 0x23 to 0x00.
- R6: In 12-hour mode (control bit 1 = 1), the hour counts BCD 0x01..0x12 and goes from 0x12 to 0x01. The PM bit toggles when the hour goes from 0x11 to 0x12.
- R7: Writing the control word so that bit 1 goes from 1 to 0 clears the PM bit on that same edge.
- R8: Flags are numbered by bit: 0 = 32 Hz, 1 = 8 Hz, 2 = 4 Hz, 3 = 1 Hz, 4 = minute, 5 = ten minutes, 6 = hour, 7 = half day, 8 = day. The half-day flag sets when the hour passes from 11 to 12 or when the day wraps. The day flag sets when 23 goes to 00, or when 11 PM goes to 12 AM.
- R9: A flag stays set until a write to address 3 carries a 1 in its bit. Writing 0 leaves it unchanged. If a cause occurs in the same cycle as the clear, the set wins.
- R10: `irq` is high exactly when some flag is set and its bit in the enable mask (address 2) is also set.
- R11: A write to the time word (address 1) loads it only while stopped, and that load also resets the sub-second divider to 0. While running, the write is ignored.
- R12: The time word packs seconds in bits 6:0, minutes in bits 14:8, the BCD hour in bits 21:16 and PM in bit 22, all read in one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse at 2^DIV_LOG2 Hz |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 time, 2 enable, 3 flags |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DIV_LOG2 = 5, so one second takes only 32 ticks. At that setting the 32 Hz flag fires on every tick. Each table entry presets the time just before a carry boundary and runs one second, so every roll-over becomes reachable. That includes the hour, half-day and day wraps in both hour modes and both minute encodings. The divider-restart rule is also in reach: the bench shows that 31 ticks after a reload are not enough and the 32nd tick is.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NSRC = 9;

    localparam int FL_32HZ  = 0;
    localparam int FL_8HZ   = 1;
    localparam int FL_4HZ   = 2;
    localparam int FL_1HZ   = 3;
    localparam int FL_MIN   = 4;
    localparam int FL_10MIN = 5;
    localparam int FL_HOUR  = 6;
    localparam int FL_HALF  = 7;
    localparam int FL_DAY   = 8;

    localparam int CTL_RUN    = 0;
    localparam int CTL_TWELVE = 1;
    localparam int CTL_BIN    = 2;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_TIME = 2'd1,
        A_IEN  = 2'd2,
        A_FLAG = 2'd3
    } addr_e;

    typedef struct packed {
        logic       pm;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } rtc_time_t;

    typedef struct packed {
        logic       carry;
        logic [6:0] val;
    } sm_step_t;

    typedef struct packed {
        logic       pm;
        logic [5:0] hour;
        logic       half;
        logic       day;
    } h_step_t;

    // divider bits below the event position for 32, 8, 4, 1 Hz
    function automatic int div_shift(input int idx);
        case (idx)
            0:       return 5;
            1:       return 3;
            2:       return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [23:0] to_word(input rtc_time_t t);
        return {1'b0, t.pm, t.hour, 1'b0, t.min, 1'b0, t.sec};
    endfunction

    function automatic rtc_time_t from_word(input logic [23:0] w);
        rtc_time_t t;
        t.pm   = w[22];
        t.hour = w[21:16];
        t.min  = w[14:8];
        t.sec  = w[6:0];
        return t;
    endfunction

    function automatic sm_step_t sm_step(input logic [6:0] v, input logic bin);
        sm_step_t r;
        r.carry = 1'b0;
        r.val   = v + 7'd1;
        if (bin) begin
            if (v >= 7'd59) begin
                r.val   = 7'd0;
                r.carry = 1'b1;
            end
        end else if (v == 7'h59) begin
            r.val   = 7'd0;
            r.carry = 1'b1;
        end else if (v[3:0] == 4'd9) begin
            r.val = {v[6:4] + 3'd1, 4'd0};
        end
        return r;
    endfunction

    function automatic logic tens_edge(input logic [6:0] v, input logic bin);
        if (bin) return (v % 7'd10) == 7'd0;
        return v[3:0] == 4'd0;
    endfunction

    function automatic h_step_t hour_step(input logic [5:0] h, input logic pm,
                                          input logic twelve);
        h_step_t r;
        r.pm   = pm;
        r.half = 1'b0;
        r.day  = 1'b0;
        if (h[3:0] == 4'd9) r.hour = {h[5:4] + 2'd1, 4'd0};
        else                r.hour = h + 6'd1;
        if (twelve) begin
            if (h == 6'h12) begin
                r.hour = 6'h01;
            end else if (h == 6'h11) begin
                r.pm   = ~pm;
                r.half = 1'b1;
                r.day  = pm;
            end
        end else begin
            if (h == 6'h23) begin
                r.hour = 6'h00;
                r.half = 1'b1;
                r.day  = 1'b1;
            end else if (h == 6'h11) begin
                r.half = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic legal12(input logic [5:0] h);
        return (h == 6'h10) || (h == 6'h11) || (h == 6'h12) ||
               (h[5:4] == 2'd0 && h[3:0] >= 4'd1 && h[3:0] <= 4'd9);
    endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider
    import rtc_pkg::*;
#(
    parameter int DIV_LOG2 = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                run,
    input  logic                clr,
    output logic [DIV_LOG2-1:0] dv,
    output logic [3:0]          dev
);
    logic adv;
    assign adv = tick & run;

    always_ff @(posedge clk) begin
        if (rst || clr) dv <= '0;
        else if (adv)   dv <= dv + 1'b1;
    end

    for (genvar i = 0; i < 4; i++) begin : g_ev
        localparam logic [DIV_LOG2-1:0] MSK =
            DIV_LOG2'((1 << (DIV_LOG2 - div_shift(i))) - 1);
        assign dev[i] = adv && ((dv & MSK) == MSK);
    end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sec_ev,
    input  logic      twelve,
    input  logic      bin,
    input  logic      load,
    input  rtc_time_t load_val,
    input  logic      pm_clr,
    output rtc_time_t tm,
    output logic      ev_min,
    output logic      ev_10min,
    output logic      ev_hour,
    output logic      ev_half,
    output logic      ev_day
);
    sm_step_t  s_nx, m_nx;
    h_step_t   h_nx;
    rtc_time_t nx;

    always_comb begin
        s_nx = sm_step(tm.sec, bin);
        m_nx = sm_step(tm.min, bin);
        h_nx = hour_step(tm.hour, tm.pm, twelve);
        nx   = tm;
        ev_min   = 1'b0;
        ev_10min = 1'b0;
        ev_hour  = 1'b0;
        ev_half  = 1'b0;
        ev_day   = 1'b0;
        if (sec_ev) begin
            nx.sec = s_nx.val;
            if (s_nx.carry) begin
                ev_min   = 1'b1;
                nx.min   = m_nx.val;
                ev_10min = tens_edge(m_nx.val, bin);
                if (m_nx.carry) begin
                    ev_hour = 1'b1;
                    nx.hour = h_nx.hour;
                    nx.pm   = h_nx.pm;
                    ev_half = h_nx.half;
                    ev_day  = h_nx.day;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tm <= '0;
        end else if (load) begin
            tm    <= load_val;
            tm.pm <= load_val.pm & twelve;
        end else if (pm_clr) begin
            tm.pm <= 1'b0;
        end else begin
            tm <= nx;
        end
    end
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq #(
    parameter int NS = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NS-1:0] set,
    input  logic          wr_ien,
    input  logic [NS-1:0] ien_d,
    input  logic [NS-1:0] clr,
    output logic [NS-1:0] ien,
    output logic [NS-1:0] flags,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ien   <= '0;
            flags <= '0;
        end else begin
            if (wr_ien) ien <= ien_d;
            flags <= (flags & ~clr) | set;
        end
    end

    assign irq = |(flags & ien);
endmodule

// File: rtl/rtc_clock_top.sv
module rtc_clock_top
    import rtc_pkg::*;
#(
    parameter int DIV_LOG2 = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [23:0] wdata,
    output logic [23:0] rdata,
    output logic        irq
);
    logic run_q, twelve_q, bin_q;
    logic wr_ctrl, wr_time, wr_ien, pm_clr;
    logic [NSRC-1:0] clr_v, set_v, ien, flags;
    logic [DIV_LOG2-1:0] dv;
    logic [3:0] dev;
    rtc_time_t tm;
    logic [23:0] time_word;
    logic ev_min, ev_10min, ev_hour, ev_half, ev_day;
    addr_e a;

    assign a       = addr_e'(addr);
    assign wr_ctrl = wr_en && a == A_CTRL;
    assign wr_time = wr_en && a == A_TIME && !run_q;
    assign wr_ien  = wr_en && a == A_IEN;
    assign clr_v   = (wr_en && a == A_FLAG) ? wdata[NSRC-1:0] : '0;
    assign pm_clr  = wr_ctrl && twelve_q && !wdata[CTL_TWELVE];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            twelve_q <= 1'b0;
            bin_q    <= 1'b0;
        end else if (wr_ctrl) begin
            run_q    <= wdata[CTL_RUN];
            twelve_q <= wdata[CTL_TWELVE];
            bin_q    <= wdata[CTL_BIN];
        end
    end

    rtc_divider #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk(clk), .rst(rst), .tick(tick), .run(run_q), .clr(wr_time),
        .dv(dv), .dev(dev)
    );

    rtc_time_core u_core (
        .clk(clk), .rst(rst), .sec_ev(dev[FL_1HZ]), .twelve(twelve_q),
        .bin(bin_q), .load(wr_time), .load_val(from_word(wdata)),
        .pm_clr(pm_clr), .tm(tm), .ev_min(ev_min), .ev_10min(ev_10min),
        .ev_hour(ev_hour), .ev_half(ev_half), .ev_day(ev_day)
    );

    assign set_v = {ev_day, ev_half, ev_hour, ev_10min, ev_min, dev};

    rtc_irq #(.NS(NSRC)) u_irq (
        .clk(clk), .rst(rst), .set(set_v), .wr_ien(wr_ien),
        .ien_d(wdata[NSRC-1:0]), .clr(clr_v), .ien(ien), .flags(flags),
        .irq(irq)
    );

    assign time_word = to_word(tm);

    always_comb begin
        case (a)
            A_CTRL:  rdata = {21'd0, bin_q, twelve_q, run_q};
            A_TIME:  rdata = time_word;
            A_IEN:   rdata = {{(24-NSRC){1'b0}}, ien};
            default: rdata = {{(24-NSRC){1'b0}}, flags};
        endcase
    end
endmodule

// File: rtl/rtc_clock_chk.sv
module rtc_clock_chk
    import rtc_pkg::*;
#(
    parameter int DIV_LOG2 = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                run,
    input logic                wr_time,
    input logic                twelve,
    input logic [23:0]         time_word,
    input logic [5:0]          hour,
    input logic                pm,
    input logic [DIV_LOG2-1:0] dv,
    input logic [NSRC-1:0]     flags,
    input logic [NSRC-1:0]     clr_v
);
    AST_STOP_HOLDS_TIME: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_time) |=> ($stable(time_word) || $fell(twelve))); // R2

    AST_STOP_HOLDS_DIV: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_time) |=> $stable(dv)); // R2

    AST_LOAD_CLEARS_DIV: assert property (@(posedge clk) disable iff (rst)
        wr_time |=> (dv == '0)); // R11

    AST_PM_DROPS: assert property (@(posedge clk) disable iff (rst)
        $fell(twelve) |-> !pm); // R7

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(flags & ~clr_v)) == $past(flags & ~clr_v))); // R9

    AST_TWELVE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (twelve && legal12(hour) && !wr_time) |=> legal12(hour)); // R6
endmodule

bind rtc_clock_top rtc_clock_chk #(.DIV_LOG2(DIV_LOG2)) u_chk (
    .clk(clk), .rst(rst), .run(run_q), .wr_time(wr_time), .twelve(twelve_q),
    .time_word(time_word), .hour(tm.hour), .pm(tm.pm), .dv(dv),
    .flags(flags), .clr_v(clr_v)
);

// File: tb/sim_rtc_clock_top.sv
module sim_rtc_clock_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [23:0] wdata = '0;
    logic [23:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rtc_clock_top #(.DIV_LOG2(5)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // {ctrl[2:0], start time, expected time, expected flags}
    localparam int NV = 17;
    localparam logic [59:0] VEC [NV] = '{
        {3'd0, 24'h000000, 24'h000001, 9'h00F},
        {3'd0, 24'h000009, 24'h000010, 9'h00F},
        {3'd0, 24'h000059, 24'h000100, 9'h01F},
        {3'd0, 24'h000959, 24'h001000, 9'h03F},
        {3'd0, 24'h005959, 24'h010000, 9'h07F},
        {3'd0, 24'h115959, 24'h120000, 9'h0FF},
        {3'd0, 24'h235959, 24'h000000, 9'h1FF},
        {3'd0, 24'h195959, 24'h200000, 9'h07F},
        {3'd2, 24'h115959, 24'h520000, 9'h0FF},
        {3'd2, 24'h515959, 24'h120000, 9'h1FF},
        {3'd2, 24'h125959, 24'h010000, 9'h07F},
        {3'd2, 24'h525959, 24'h410000, 9'h07F},
        {3'd4, 24'h00003B, 24'h000100, 9'h01F},
        {3'd4, 24'h00093B, 24'h000A00, 9'h03F},
        {3'd4, 24'h003B3B, 24'h010000, 9'h07F},
        {3'd4, 24'h000A3B, 24'h000B00, 9'h01F},
        {3'd0, 24'h000958, 24'h000959, 9'h00F}
    };

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [23:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [23:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 24'h0);
        rd(2'd1, v); chk("R1 time", v, 24'h0);
        rd(2'd2, v); chk("R1 ien", v, 24'h0);
        rd(2'd3, v); chk("R1 flags", v, 24'h0);
        chk("R1 irq", {23'd0, irq}, 24'h0);

        // R2 stopped: ticks have no effect
        ticks(40);
        rd(2'd1, v); chk("R2 time held while stopped", v, 24'h0);
        rd(2'd3, v); chk("R2 no flags while stopped", v, 24'h0);

        // table: one second from a preset time (R3 R4 R5 R6 R8 R12)
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  c;
            logic [23:0] st, ex;
            logic [8:0]  ef;
            {c, st, ex, ef} = VEC[i];
            wr(2'd0, {21'd0, c});
            wr(2'd3, 24'h1FF);
            wr(2'd1, st);
            wr(2'd0, {21'd0, c | 3'd1});
            ticks(32);
            wr(2'd0, {21'd0, c});
            rd(2'd1, v); chk("R3/R4/R5/R6/R12 time after one second", v, ex);
            rd(2'd3, v); chk("R8 flags after one second", v, {15'd0, ef});
        end

        // R9 and R10: flags now hold 0x00F
        wr(2'd2, 24'h000);
        chk("R10 irq masked", {23'd0, irq}, 24'h0);
        wr(2'd2, 24'h008);
        chk("R10 irq enabled", {23'd0, irq}, 24'h1);
        wr(2'd3, 24'h008);
        rd(2'd3, v); chk("R9 write-1 clears one flag", v, 24'h007);
        chk("R10 irq after clear", {23'd0, irq}, 24'h0);
        wr(2'd3, 24'h000);
        rd(2'd3, v); chk("R9 write-0 keeps flags", v, 24'h007);

        // R11 divider restart on time load
        wr(2'd1, 24'h000000);
        wr(2'd0, 24'h1);
        ticks(10);
        wr(2'd0, 24'h0);
        wr(2'd1, 24'h000005);
        wr(2'd0, 24'h1);
        ticks(31);
        rd(2'd1, v); chk("R11 divider restarted: 31 ticks", v, 24'h000005);
        ticks(1);
        rd(2'd1, v); chk("R11 divider restarted: 32nd tick", v, 24'h000006);
        wr(2'd1, 24'h123456);
        rd(2'd1, v); chk("R11 load ignored while running", v, 24'h000006);

        // R6 / R7 PM handling on mode change
        wr(2'd0, 24'h2);
        wr(2'd1, 24'h510000);
        rd(2'd1, v); chk("R6 PM held in 12-hour mode", v, 24'h510000);
        wr(2'd0, 24'h0);
        rd(2'd1, v); chk("R7 PM cleared on 24-hour switch", v, 24'h110000);
        rd(2'd0, v); chk("R7 control reads back", v, 24'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule